// File: doc/BRIEF.md
# Single-Channel Minor-Loop Transfer Engine

This block performs the inner ("minor") loop of a memory-to-memory copy for one channel. When a service request arrives while it is idle, it spends one cycle taking a transfer descriptor from descriptor storage. The descriptor holds a source address, a destination address, a byte count, an iteration count, and a size and a wrap window for each side. The block then moves the whole byte count as a series of read beats and write beats. After the last beat it returns the advanced addresses and the decremented iteration count to storage in a single write-back cycle. If that count has reached zero, it also flags that the outer loop is finished.

Once a minor loop has started it cannot be cancelled. A stall input can freeze it between beats, and it then picks up exactly where it stopped. A request that arrives during a loop is remembered and served after the current write-back. The memory side is a plain single-cycle read/write port, and read data is accepted in the cycle the read is issued.

Top module: `dmx_minor_engine`

## Requirements
- R1: When `svc_req_i` is high in an idle cycle, the next cycle raises `desc_rd_o` for exactly one cycle and issues no memory access. The first read follows in the cycle after that, unless stalled.
- R2: Each beat is one cycle with `mem_rd_o` at the source address, followed by one cycle with `mem_wr_o` at the destination address. `mem_wdata_o` carries the word that was read. Read and write are never high together.
- R3: The size codes 0, 1 and 2 mean 1, 2 and 4 bytes, and codes 3 to 7 are taken as 4 bytes. A beat uses the smaller of the two sides' sizes. It shrinks to the largest of 4, 2 or 1 bytes that does not exceed the bytes still left. `mem_size_o` gives the base-2 log of the beat's byte count.
- R4: After each write beat, both addresses advance by the beat's byte count. If a side's 5-bit wrap value m is non-zero, the address bits at positions m and above stay fixed, and the low m bits wrap around.
- R5: The total bytes written in one minor loop equal the 32-bit byte count. A count of 0 means 2^32 bytes.
- R6: While `stall_i` is high during the beat phase, neither a read nor a write is issued. The remaining count and the addresses hold, and progress resumes from the same point.
- R7: A request that arrives while the engine is busy neither restarts nor shortens the running loop. At most one such request is kept, and it starts a new descriptor load after the write-back.
- R8: In the cycle after the last write beat, `desc_wr_o` is high for one cycle. It carries the advanced source and destination addresses and the iteration count minus one, with a count of 0 staying 0.
- R9: `done_o` is high in the write-back cycle exactly when the written iteration count is 0.
- R10: While reset is asserted, and in the first cycle after it, all strobes (`desc_rd_o`, `desc_wr_o`, `mem_rd_o`, `mem_wr_o`, `done_o`) are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| svc_req_i | input | 1 | Service request |
| stall_i | input | 1 | Freeze the beat phase |
| desc_rd_o | output | 1 | Descriptor fields are sampled this cycle |
| desc_saddr_i | input | AW | Stored source address |
| desc_daddr_i | input | AW | Stored destination address |
| desc_nbytes_i | input | CNT_W | Stored byte count (0 = 2^32) |
| desc_citer_i | input | CIT_W | Stored iteration count |
| desc_ssize_i | input | 3 | Source size code |
| desc_dsize_i | input | 3 | Destination size code |
| desc_smod_i | input | 5 | Source wrap window bits |
| desc_dmod_i | input | 5 | Destination wrap window bits |
| desc_wr_o | output | 1 | Write-back strobe |
| desc_wsaddr_o | output | AW | Source address to store |
| desc_wdaddr_o | output | AW | Destination address to store |
| desc_wciter_o | output | CIT_W | Iteration count to store |
| mem_rd_o | output | 1 | Memory read strobe |
| mem_raddr_o | output | AW | Read address |
| mem_rdata_i | input | 32 | Read data, valid in the read cycle |
| mem_wr_o | output | 1 | Memory write strobe |
| mem_waddr_o | output | AW | Write address |
| mem_wdata_o | output | 32 | Write data |
| mem_size_o | output | 2 | Beat size as the base-2 log of its byte count |
| done_o | output | 1 | Outer-loop completion flag |

## Verification
The assertions assume that the descriptor inputs hold valid values in the load cycle. They also assume that memory answers a read in the same cycle, so the beat phase advances whenever `stall_i` is low. The bench keeps to these assumptions: it models storage and memory as ideal combinational responders. It changes descriptor contents only while the engine is idle, and it writes back exactly what the engine reports. Stall patterns and repeated requests are applied at any point in a loop, since the block must accept them at any time.

// File: rtl/dmx_pkg.sv
package dmx_pkg;
  localparam int DW    = 32;
  localparam int SZ_W  = 3;
  localparam int MOD_W = 5;

  typedef enum logic [2:0] {
    ST_IDLE  = 3'd0,
    ST_LOAD  = 3'd1,
    ST_READ  = 3'd2,
    ST_WRITE = 3'd3,
    ST_WBACK = 3'd4
  } eng_st_e;

  // Reduce a 3-bit size code to a log2 byte count of 0..2.
  function automatic logic [1:0] clip_size(input logic [SZ_W-1:0] code);
    logic [1:0] r;
    if (code >= 3'd2) r = 2'd2;
    else              r = code[1:0];
    return r;
  endfunction

  function automatic logic [1:0] min_size(input logic [1:0] a, input logic [1:0] b);
    return (a < b) ? a : b;
  endfunction
endpackage

// File: rtl/dmx_addr_step.sv
module dmx_addr_step #(
  parameter int AW    = 32,
  parameter int MOD_W = 5
) (
  input  logic [AW-1:0]    addr_i,
  input  logic [MOD_W-1:0] mod_i,
  input  logic [2:0]       bytes_i,
  output logic [AW-1:0]    addr_o
);
  logic [AW-1:0] low_mask;
  logic [AW-1:0] sum;

  always_comb begin
    if (mod_i == '0) low_mask = '1;
    else             low_mask = (AW'(1) << mod_i) - AW'(1);
    sum    = addr_i + AW'(bytes_i);
    addr_o = (addr_i & ~low_mask) | (sum & low_mask);
  end
endmodule

// File: rtl/dmx_byte_cnt.sv
module dmx_byte_cnt #(
  parameter int CNT_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load_i,
  input  logic [CNT_W-1:0] nbytes_i,
  input  logic             dec_i,
  input  logic [1:0]       cap_i,
  output logic [1:0]       eff_o,
  output logic [2:0]       bytes_o,
  output logic             last_o
);
  localparam int RW = CNT_W + 1;

  logic [RW-1:0] rem_q;
  logic [RW-1:0] rem_d;
  logic          rem_en;
  logic          fits4;
  logic          fits2;

  always_comb begin
    fits4 = (rem_q >= RW'(4));
    fits2 = (rem_q >= RW'(2));
    if (cap_i == 2'd2 && fits4)      eff_o = 2'd2;
    else if (cap_i != 2'd0 && fits2) eff_o = 2'd1;
    else                             eff_o = 2'd0;
    bytes_o = 3'(1) << eff_o;
    last_o  = (rem_q == RW'(bytes_o));
  end

  always_comb begin
    rem_en = load_i | dec_i;
    rem_d  = rem_q;
    if (load_i) begin
      if (nbytes_i == '0) rem_d = {1'b1, {CNT_W{1'b0}}};
      else                rem_d = {1'b0, nbytes_i};
    end else if (dec_i) begin
      rem_d = rem_q - RW'(bytes_o);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      rem_q <= '0;
    else if (rem_en) rem_q <= rem_d;
  end

  // R5: a beat never takes more bytes than remain
  p_no_underflow_r5: assert property (@(posedge clk) disable iff (!rst_n)
    dec_i |-> (rem_q >= RW'(bytes_o)));

  // R5: a non-final beat leaves bytes to move
  p_not_empty_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (dec_i && !last_o) |=> (rem_q != '0));
endmodule

// File: rtl/dmx_minor_engine.sv
module dmx_minor_engine
  import dmx_pkg::*;
#(
  parameter int AW    = 32,
  parameter int CNT_W = 32,
  parameter int CIT_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              svc_req_i,
  input  logic              stall_i,
  output logic              desc_rd_o,
  input  logic [AW-1:0]     desc_saddr_i,
  input  logic [AW-1:0]     desc_daddr_i,
  input  logic [CNT_W-1:0]  desc_nbytes_i,
  input  logic [CIT_W-1:0]  desc_citer_i,
  input  logic [SZ_W-1:0]   desc_ssize_i,
  input  logic [SZ_W-1:0]   desc_dsize_i,
  input  logic [MOD_W-1:0]  desc_smod_i,
  input  logic [MOD_W-1:0]  desc_dmod_i,
  output logic              desc_wr_o,
  output logic [AW-1:0]     desc_wsaddr_o,
  output logic [AW-1:0]     desc_wdaddr_o,
  output logic [CIT_W-1:0]  desc_wciter_o,
  output logic              mem_rd_o,
  output logic [AW-1:0]     mem_raddr_o,
  input  logic [DW-1:0]     mem_rdata_i,
  output logic              mem_wr_o,
  output logic [AW-1:0]     mem_waddr_o,
  output logic [DW-1:0]     mem_wdata_o,
  output logic [1:0]        mem_size_o,
  output logic              done_o
);
  localparam int NSIDE = 2;

  eng_st_e          st_q, st_d;
  logic             pend_q, pend_d;
  logic [AW-1:0]    sa_q, sa_d, da_q, da_d;
  logic [CIT_W-1:0] cit_q, cit_d, cit_nx;
  logic [MOD_W-1:0] smod_q, smod_d, dmod_q, dmod_d;
  logic [1:0]       cap_q, cap_d;
  logic [DW-1:0]    hold_q, hold_d;

  logic             adr_en, cfg_en, hold_en;
  logic             cnt_load, cnt_dec;
  logic [1:0]       eff_sz;
  logic [2:0]       beat_bytes;
  logic             beat_last;

  logic [AW-1:0]    step_in  [NSIDE];
  logic [AW-1:0]    step_out [NSIDE];
  logic [MOD_W-1:0] step_mod [NSIDE];

  assign step_in[0]  = sa_q;
  assign step_in[1]  = da_q;
  assign step_mod[0] = smod_q;
  assign step_mod[1] = dmod_q;

  for (genvar gi = 0; gi < NSIDE; gi++) begin : g_side
    dmx_addr_step #(.AW(AW), .MOD_W(MOD_W)) u_step (
      .addr_i  (step_in[gi]),
      .mod_i   (step_mod[gi]),
      .bytes_i (beat_bytes),
      .addr_o  (step_out[gi])
    );
  end

  dmx_byte_cnt #(.CNT_W(CNT_W)) u_cnt (
    .clk      (clk),
    .rst_n    (rst_n),
    .load_i   (cnt_load),
    .nbytes_i (desc_nbytes_i),
    .dec_i    (cnt_dec),
    .cap_i    (cap_q),
    .eff_o    (eff_sz),
    .bytes_o  (beat_bytes),
    .last_o   (beat_last)
  );

  assign cit_nx = (cit_q == '0) ? '0 : (cit_q - CIT_W'(1));

  // Next-state and strobe logic
  always_comb begin
    st_d      = st_q;
    pend_d    = pend_q;
    sa_d      = sa_q;
    da_d      = da_q;
    cit_d     = cit_q;
    smod_d    = smod_q;
    dmod_d    = dmod_q;
    cap_d     = cap_q;
    hold_d    = hold_q;
    adr_en    = 1'b0;
    cfg_en    = 1'b0;
    hold_en   = 1'b0;
    cnt_load  = 1'b0;
    cnt_dec   = 1'b0;
    desc_rd_o = 1'b0;
    desc_wr_o = 1'b0;
    mem_rd_o  = 1'b0;
    mem_wr_o  = 1'b0;
    done_o    = 1'b0;

    if (st_q != ST_IDLE && svc_req_i) pend_d = 1'b1;

    case (st_q)
      ST_IDLE: begin
        if (svc_req_i || pend_q) begin
          st_d   = ST_LOAD;
          pend_d = 1'b0;
        end
      end
      ST_LOAD: begin
        desc_rd_o = 1'b1;
        adr_en    = 1'b1;
        cfg_en    = 1'b1;
        cnt_load  = 1'b1;
        sa_d      = desc_saddr_i;
        da_d      = desc_daddr_i;
        cit_d     = desc_citer_i;
        smod_d    = desc_smod_i;
        dmod_d    = desc_dmod_i;
        cap_d     = min_size(clip_size(desc_ssize_i), clip_size(desc_dsize_i));
        st_d      = ST_READ;
      end
      ST_READ: begin
        if (!stall_i) begin
          mem_rd_o = 1'b1;
          hold_en  = 1'b1;
          hold_d   = mem_rdata_i;
          st_d     = ST_WRITE;
        end
      end
      ST_WRITE: begin
        if (!stall_i) begin
          mem_wr_o = 1'b1;
          cnt_dec  = 1'b1;
          adr_en   = 1'b1;
          sa_d     = step_out[0];
          da_d     = step_out[1];
          st_d     = beat_last ? ST_WBACK : ST_READ;
        end
      end
      ST_WBACK: begin
        desc_wr_o = 1'b1;
        done_o    = (cit_nx == '0);
        st_d      = ST_IDLE;
      end
      default: st_d = ST_IDLE;
    endcase
  end

  always_comb begin
    mem_raddr_o   = sa_q;
    mem_waddr_o   = da_q;
    mem_wdata_o   = hold_q;
    mem_size_o    = (mem_rd_o || mem_wr_o) ? eff_sz : 2'd0;
    desc_wsaddr_o = sa_q;
    desc_wdaddr_o = da_q;
    desc_wciter_o = cit_nx;
  end

  // Control registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= ST_IDLE;
      pend_q <= 1'b0;
    end else begin
      st_q   <= st_d;
      pend_q <= pend_d;
    end
  end

  // Datapath registers with explicit enables
  always_ff @(posedge clk) begin
    if (adr_en) begin
      sa_q <= sa_d;
      da_q <= da_d;
    end
    if (cfg_en) begin
      cit_q  <= cit_d;
      smod_q <= smod_d;
      dmod_q <= dmod_d;
      cap_q  <= cap_d;
    end
    if (hold_en) hold_q <= hold_d;
  end

  // Assertions
  logic [AW-1:0] src_hi;
  assign src_hi = ~((AW'(1) << smod_q) - AW'(1));

  p_rw_excl_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !(mem_rd_o && mem_wr_o));

  p_stall_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (stall_i && (st_q == ST_READ || st_q == ST_WRITE)) |=> $stable(st_q));

  p_mod_fence_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_wr_o && smod_q != '0) |=> ((sa_q & src_hi) == ($past(sa_q) & src_hi)));

  p_pend_keep_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (svc_req_i && st_q != ST_IDLE) |=> pend_q);

  p_wb_after_wr_r8: assert property (@(posedge clk) disable iff (!rst_n)
    desc_wr_o |-> $past(mem_wr_o));

  p_done_zero_r9: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> (desc_wr_o && desc_wciter_o == '0));

  p_load_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
    desc_rd_o |-> (!mem_rd_o && !mem_wr_o && !desc_wr_o));
endmodule

// File: tb/dmx_minor_engine_bench.sv
module dmx_minor_engine_bench;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  logic        req = 1'b0, stall = 1'b0;
  logic [31:0] s_sa = '0, s_da = '0, s_nb = '0;
  logic [15:0] s_cit = '0;
  logic [2:0]  s_ssz = '0, s_dsz = '0;
  logic [4:0]  s_smod = '0, s_dmod = '0;

  logic        desc_rd, desc_wr, mem_rd, mem_wr, done;
  logic [31:0] wsaddr, wdaddr, raddr, waddr, wdata, rdata;
  logic [15:0] wciter;
  logic [1:0]  msize;

  function automatic logic [31:0] pattern(input logic [31:0] a);
    logic [31:0] p;
    p = a * 32'h9E3779B1;
    return p ^ 32'h5A5A0000;
  endfunction

  assign rdata = pattern(raddr);

  dmx_minor_engine u_dmx_minor_engine (
    .clk(clk), .rst_n(rst_n), .svc_req_i(req), .stall_i(stall),
    .desc_rd_o(desc_rd), .desc_saddr_i(s_sa), .desc_daddr_i(s_da),
    .desc_nbytes_i(s_nb), .desc_citer_i(s_cit), .desc_ssize_i(s_ssz),
    .desc_dsize_i(s_dsz), .desc_smod_i(s_smod), .desc_dmod_i(s_dmod),
    .desc_wr_o(desc_wr), .desc_wsaddr_o(wsaddr), .desc_wdaddr_o(wdaddr),
    .desc_wciter_o(wciter), .mem_rd_o(mem_rd), .mem_raddr_o(raddr),
    .mem_rdata_i(rdata), .mem_wr_o(mem_wr), .mem_waddr_o(waddr),
    .mem_wdata_o(wdata), .mem_size_o(msize), .done_o(done)
  );

  int n_chk = 0, n_fail = 0;
  bit finished = 0;

  task automatic chk(input bit ok, input string rq, input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", rq, act, exp);
    end
  endtask

  // Behavioural reference state
  int          m_st = 0;          // 0 idle,1 load,2 read,3 write,4 write-back
  bit          m_pend = 0;
  longint      m_sa, m_da, m_rem;
  int          m_cit, m_cap, m_smod, m_dmod;
  logic [31:0] m_hold;
  // Observations
  int loads = 0, beats = 0, dones = 0, wbs = 0;
  longint moved = 0;
  logic [31:0] c_ws, c_wd;
  logic [15:0] c_wc;

  function automatic int szb(input int s);
    return (s == 0) ? 1 : (s == 1) ? 2 : 4;
  endfunction

  function automatic int lg(input int b);
    return (b == 1) ? 0 : (b == 2) ? 1 : 2;
  endfunction

  function automatic longint stepa(input longint a, input int m, input int b);
    longint span;
    if (m == 0) return (a + b) % 64'h1_0000_0000;
    span = longint'(1) << m;
    return (a / span) * span + ((a % span) + b) % span;
  endfunction

  task automatic cyc(input bit r, input bit s);
    bit e_drd, e_rd, e_wr, e_dwr, e_done, np;
    int nst, b, wc;
    @(negedge clk);
    req = r; stall = s;
    #1;
    e_drd = 0; e_rd = 0; e_wr = 0; e_dwr = 0; e_done = 0;
    nst = m_st; np = m_pend;
    if (m_st != 0 && r) np = 1;
    b = m_cap;
    while (longint'(b) > m_rem && b > 1) b = b / 2;
    wc = (m_cit == 0) ? 0 : m_cit - 1;
    case (m_st)
      0: if (r || m_pend) begin nst = 1; np = 0; end
      1: begin
        e_drd = 1;
        m_sa = s_sa; m_da = s_da; m_cit = s_cit;
        m_rem = (s_nb == 0) ? 64'h1_0000_0000 : longint'(s_nb);
        m_cap = (szb(s_ssz) < szb(s_dsz)) ? szb(s_ssz) : szb(s_dsz);
        m_smod = s_smod; m_dmod = s_dmod;
        nst = 2;
      end
      2: if (!s) begin
        e_rd = 1;
        chk(raddr == m_sa[31:0], "R2", raddr, m_sa);
        chk(msize == lg(b), "R3", msize, lg(b));
        m_hold = pattern(m_sa[31:0]);
        nst = 3;
      end
      3: if (!s) begin
        e_wr = 1;
        chk(waddr == m_da[31:0], "R4", waddr, m_da);
        chk(wdata == m_hold, "R2", wdata, m_hold);
        chk(msize == lg(b), "R3", msize, lg(b));
        m_sa = stepa(m_sa, m_smod, b);
        m_da = stepa(m_da, m_dmod, b);
        m_rem = m_rem - b;
        moved += b;
        nst = (m_rem == 0) ? 4 : 2;
      end
      default: begin
        e_dwr = 1; e_done = (wc == 0);
        chk(wsaddr == m_sa[31:0], "R8", wsaddr, m_sa);
        chk(wdaddr == m_da[31:0], "R8", wdaddr, m_da);
        chk(wciter == wc[15:0], "R8", wciter, wc);
        s_sa = m_sa[31:0]; s_da = m_da[31:0]; s_cit = wc[15:0];
        nst = 0;
      end
    endcase
    chk(desc_rd == e_drd, "R1", desc_rd, e_drd);
    chk(mem_rd == e_rd, "R6", mem_rd, e_rd);
    chk(mem_wr == e_wr, "R6", mem_wr, e_wr);
    chk(desc_wr == e_dwr, "R8", desc_wr, e_dwr);
    chk(done == e_done, "R9", done, e_done);
    if (desc_rd) loads++;
    if (mem_wr) beats++;
    if (done) dones++;
    if (desc_wr) begin wbs++; c_ws = wsaddr; c_wd = wdaddr; c_wc = wciter; end
    m_st = nst; m_pend = np;
  endtask

  task automatic wait_idle(input int limit, input int stall_every);
    int k = 0;
    while ((m_st != 0 || m_pend) && k < limit) begin
      cyc(0, stall_every > 0 && (k % stall_every) == 1);
      k++;
    end
    chk(k < limit, "R5", k, limit);
  endtask

  task automatic set_desc(input logic [31:0] sa, input logic [31:0] da, input logic [31:0] nb,
                          input logic [15:0] ci, input logic [2:0] ss, input logic [2:0] ds,
                          input logic [4:0] sm, input logic [4:0] dm);
    s_sa = sa; s_da = da; s_nb = nb; s_cit = ci;
    s_ssz = ss; s_dsz = ds; s_smod = sm; s_dmod = dm;
    beats = 0; moved = 0; dones = 0; wbs = 0; loads = 0;
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0; req = 0; stall = 0;
    repeat (2) begin
      @(negedge clk);
      chk(!desc_rd && !desc_wr && !mem_rd && !mem_wr && !done, "R10",
          {desc_rd, desc_wr, mem_rd, mem_wr, done}, 0);
    end
    rst_n = 1'b1;
    m_st = 0; m_pend = 0;
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    if (!finished) begin
      n_chk++; n_fail++;
      $display("FAIL R10 watchdog actual=running expected=finished");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    do_reset();
    cyc(0, 0);

    // Aligned 4-byte copy
    set_desc(32'h1000, 32'h2000, 16, 3, 3'd2, 3'd2, 0, 0);
    cyc(1, 0);
    wait_idle(200, 0);
    chk(beats == 4, "R3", beats, 4);
    chk(c_ws == 32'h1010 && c_wd == 32'h2010, "R8", c_ws, 32'h1010);
    chk(c_wc == 16'd2, "R8", c_wc, 2);
    chk(dones == 0, "R9", dones, 0);

    // Second loop continues from stored addresses
    cyc(1, 0);
    wait_idle(200, 0);
    chk(c_ws == 32'h1020, "R8", c_ws, 32'h1020);

    // Odd count shrinks the tail beats: 4,2,1
    set_desc(32'h3000, 32'h4001, 7, 5, 3'd2, 3'd2, 0, 0);
    cyc(1, 0);
    wait_idle(200, 0);
    chk(beats == 3 && moved == 7, "R5", moved, 7);
    chk(c_ws == 32'h3007 && c_wd == 32'h4008, "R4", c_wd, 32'h4008);

    // Mixed sizes: smaller side wins; reserved code counts as 4 bytes
    set_desc(32'h5000, 32'h6000, 5, 5, 3'd0, 3'd5, 0, 0);
    cyc(1, 0);
    wait_idle(200, 0);
    chk(beats == 5, "R3", beats, 5);

    // Source wrap in a 16-byte window
    set_desc(32'h10F8, 32'h7000, 16, 5, 3'd2, 3'd2, 5'd4, 0);
    cyc(1, 0);
    wait_idle(200, 0);
    chk(c_ws == 32'h10F8, "R4", c_ws, 32'h10F8);
    chk(c_wd == 32'h7010, "R4", c_wd, 32'h7010);

    // Destination wrap in an 8-byte window, 2-byte beats
    set_desc(32'h8000, 32'h2006, 8, 5, 3'd1, 3'd1, 0, 5'd3);
    cyc(1, 0);
    wait_idle(200, 0);
    chk(c_wd == 32'h2006 && beats == 4, "R4", c_wd, 32'h2006);

    // Stalls in the beat phase
    set_desc(32'h9000, 32'hA000, 24, 5, 3'd2, 3'd2, 0, 0);
    cyc(1, 0);
    wait_idle(400, 3);
    chk(moved == 24 && c_ws == 32'h9018, "R6", moved, 24);

    // Requests while busy collapse into one pending load
    set_desc(32'hB000, 32'hC000, 12, 2, 3'd2, 3'd2, 0, 0);
    cyc(1, 0);
    cyc(0, 0); cyc(1, 0); cyc(1, 1); cyc(1, 0);
    wait_idle(400, 0);
    chk(loads == 2, "R7", loads, 2);
    chk(moved == 24, "R7", moved, 24);
    chk(dones == 1 && c_wc == 0, "R9", dones, 1);

    // Iteration count of zero stays zero and signals done
    set_desc(32'hD000, 32'hE000, 4, 0, 3'd2, 3'd2, 0, 0);
    cyc(1, 0);
    wait_idle(100, 0);
    chk(c_wc == 0 && dones == 1, "R9", c_wc, 0);

    // Zero count means 2^32 bytes: still running after many beats
    set_desc(32'h0, 32'h4000_0000, 0, 3, 3'd2, 3'd2, 0, 0);
    cyc(1, 0);
    for (int k = 0; k < 600; k++) cyc(0, 0);
    chk(wbs == 0, "R5", wbs, 0);
    chk(moved == 4 * beats && beats > 250, "R5", beats, 299);
    do_reset();
    cyc(0, 0);
    chk(!mem_rd && !mem_wr, "R10", mem_rd, 0);

    finished = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule